// File: doc/BRIEF.md
# SMBus Host Byte-Read Controller

This block is a bus master that fetches single bytes from a slave device on a two-wire SMBus/I2C bus. Software works through a small 8-bit register window: it loads a slave address and, when needed, an offset byte, then writes a start code. The controller produces the wire sequence on open-drain clock and data lines and places the received byte in a data register.

Two read forms are supported. The first writes the offset to the slave, issues a repeated START and then reads one byte. The second reads one byte from the slave's current internal pointer, with no offset phase; this form is the fast one when walking through a slave's memory in order. Completion is reported by a done flag that software clears by writing ones. A read has succeeded only if the status register then reads exactly 0x02.

Top module: `smb_rd_host`

## Requirements
- R1: After reset the status (offset 0x0) and auxiliary status (offset 0x1) read 0x00, the clock divider (offset 0xE) reads the parameter DIV_RST (default 41), and both bus lines are released.
- R2: The register window uses these offsets: 0x0 status, 0x1 auxiliary status, 0x2 start/control, 0x3 offset byte, 0x4 slave address (7-bit address in bits 7:1, bit 0 held as written), 0x5 received data, 0xE clock divider. Reads return data on the cycle after the address is presented.
- R3: Writing 0x48 to offset 0x2 while idle starts an offset read, writing 0x44 starts a current-pointer read, and status bit 0 (busy) reads as 1 from the clock edge of that write. Any other value written there starts nothing.
- R4: An offset read produces START, address with write bit (0), offset byte, repeated START, address with read bit (1), one data byte, NACK and STOP. A current-pointer read produces START, address with read bit, one data byte, NACK and STOP, with no offset phase.
- R5: When a read ends without error, the byte received most significant bit first is readable at offset 0x5. A failed read leaves offset 0x5 unchanged.
- R6: Busy clears and status bit 1 (done) sets on the same clock edge, when STOP completes. A successful read leaves the status at exactly 0x02.
- R7: A slave that does not acknowledge the address byte causes status bit 2 (device error) and auxiliary bit 0 to set. The controller then issues STOP, ends the read and still sets done, so the status reads 0x06.
- R8: A slave that does not acknowledge the offset byte causes status bit 2 and auxiliary bit 1 to set, followed by STOP and done.
- R9: Status bits 1 and 2 and auxiliary bits 0 and 1 are cleared by writing 1 to them (0xFF to offset 0x0, 0x1F to offset 0x1). Clearing one register leaves the other unchanged.
- R10: While busy is set, writes to offsets 0x2, 0x3 and 0x4 are ignored: the stored bytes keep their values and no second read starts.
- R11: In each data bit the clock line is released for exactly 2 x divider input-clock cycles, and the full bit slot is 4 x divider cycles plus two handoff cycles. A divider of 0 acts as 1.
- R12: The bus lines are only pulled low or released. SDA changes while SCL is released only during START, repeated START or STOP, and both lines are released whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the address |
| sda_in | input | 1 | Sampled level of the data line |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bound checker watches, on every cycle, the rules that follow from the register interface and the line drivers. These are: busy rising on an accepted start code and never on a rejected one, done set at the moment busy falls, the address and offset bytes held while busy, both lines released while idle, and SDA moving under a released SCL only inside START, repeated START or STOP. Some properties can only be seen from the bench's scenarios against a modelled slave memory: the exact byte sequence of each read form, the data returned, the slave pointer advancing between current-pointer reads, and the handling of a NACK on the address or on the offset. The same holds for the status codes, the write-one-to-clear behaviour and the measured SCL high time for two divider values.

// File: rtl/smb_rd_pkg.sv
package smb_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_SADR = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DATA = 4'h5;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 4'hE;

  localparam logic [BYTE_W-1:0] CODE_OFS_RD = 8'h48;
  localparam logic [BYTE_W-1:0] CODE_CUR_RD = 8'h44;

  // bus primitive executed by the bit engine
  typedef enum logic [2:0] {
    BC_START, BC_RSTART, BC_STOP, BC_WR, BC_RD
  } bitcmd_t;
endpackage

// File: rtl/smb_bit_eng.sv
module smb_bit_eng
  import smb_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  bitcmd_t           cmd,
  input  logic              wbit,
  input  logic [BYTE_W-1:0] div,
  input  logic              sda_in,
  output logic              done,
  output logic              rbit,
  output logic              scl_low,
  output logic              sda_low
);
  logic              act;
  logic [1:0]        q;
  logic [BYTE_W-1:0] cnt;
  logic [BYTE_W-1:0] div_eff;
  bitcmd_t           cmd_q;
  logic              wb_q;

  assign div_eff = (div == '0) ? {{(BYTE_W-1){1'b0}}, 1'b1} : div;

  // line levels per quarter: {scl_low, sda_low}
  function automatic logic [1:0] drv(bitcmd_t c, logic [1:0] ph, logic b);
    case (c)
      BC_START:  drv = (ph == 2'd3) ? 2'b11 : (ph == 2'd2) ? 2'b01 : 2'b00;
      BC_RSTART: drv = (ph == 2'd3) ? 2'b11 : (ph == 2'd2) ? 2'b01 :
                       (ph == 2'd1) ? 2'b00 : 2'b10;
      BC_STOP:   drv = (ph == 2'd0) ? 2'b11 : (ph == 2'd1) ? 2'b01 : 2'b00;
      BC_WR:     drv = {(ph == 2'd0) || (ph == 2'd3), ~b};
      default:   drv = {(ph == 2'd0) || (ph == 2'd3), 1'b0};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      q       <= 2'd0;
      cnt     <= '0;
      cmd_q   <= BC_STOP;
      wb_q    <= 1'b1;
      done    <= 1'b0;
      rbit    <= 1'b1;
      scl_low <= 1'b0;
      sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!act) begin
        if (go) begin
          act   <= 1'b1;
          q     <= 2'd0;
          cnt   <= '0;
          cmd_q <= cmd;
          wb_q  <= wbit;
          {scl_low, sda_low} <= drv(cmd, 2'd0, wbit);
        end
      end else if (cnt >= div_eff - 1'b1) begin
        cnt <= '0;
        if (q == 2'd1) rbit <= sda_in;   // sampled at end of first high quarter
        if (q == 2'd3) begin
          act  <= 1'b0;
          done <= 1'b1;
        end else begin
          q <= q + 2'd1;
          {scl_low, sda_low} <= drv(cmd_q, q + 2'd1, wb_q);
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
  import smb_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              with_off,
  input  logic [6:0]        sadr,
  input  logic [BYTE_W-1:0] off_byte,
  input  logic              eng_done,
  input  logic              eng_rbit,
  output logic              eng_go,
  output bitcmd_t           eng_cmd,
  output logic              eng_wbit,
  output logic              fin,
  output logic              nack_adr,
  output logic              nack_off,
  output logic [BYTE_W-1:0] rx_byte
);
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START, SQ_TX, SQ_TXACK, SQ_RSTART, SQ_RX, SQ_RXACK, SQ_STOP
  } seq_t;
  typedef enum logic [1:0] {PH_AW, PH_OFF, PH_AR} phase_t;

  seq_t              st;
  phase_t            ph;
  logic              mode_off;
  logic [BYTE_W-1:0] sh;
  logic [2:0]        bcnt;
  logic [BYTE_W-1:0] nxt_byte;

  always_comb begin
    if (st == SQ_START)                        nxt_byte = {sadr, ~mode_off};
    else if (st == SQ_TXACK && ph == PH_AW)    nxt_byte = off_byte;
    else                                       nxt_byte = {sadr, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      ph       <= PH_AW;
      mode_off <= 1'b0;
      sh       <= '0;
      bcnt     <= 3'd0;
      eng_go   <= 1'b0;
      eng_cmd  <= BC_STOP;
      eng_wbit <= 1'b1;
      fin      <= 1'b0;
      nack_adr <= 1'b0;
      nack_off <= 1'b0;
      rx_byte  <= '0;
    end else begin
      eng_go <= 1'b0;
      fin    <= 1'b0;
      case (st)
        SQ_IDLE: if (start) begin
          st       <= SQ_START;
          mode_off <= with_off;
          nack_adr <= 1'b0;
          nack_off <= 1'b0;
          eng_go   <= 1'b1;
          eng_cmd  <= BC_START;
        end
        SQ_START, SQ_RSTART: if (eng_done) begin
          ph       <= (st == SQ_START && mode_off) ? PH_AW : PH_AR;
          st       <= SQ_TX;
          bcnt     <= 3'd7;
          sh       <= {nxt_byte[BYTE_W-2:0], 1'b0};
          eng_wbit <= nxt_byte[BYTE_W-1];
          eng_go   <= 1'b1;
          eng_cmd  <= BC_WR;
        end
        SQ_TX: if (eng_done) begin
          eng_go <= 1'b1;
          if (bcnt == 3'd0) begin
            st      <= SQ_TXACK;
            eng_cmd <= BC_RD;
          end else begin
            bcnt     <= bcnt - 3'd1;
            eng_cmd  <= BC_WR;
            eng_wbit <= sh[BYTE_W-1];
            sh       <= {sh[BYTE_W-2:0], 1'b0};
          end
        end
        SQ_TXACK: if (eng_done) begin
          eng_go <= 1'b1;
          if (eng_rbit) begin
            if (ph == PH_OFF) nack_off <= 1'b1;
            else              nack_adr <= 1'b1;
            st      <= SQ_STOP;
            eng_cmd <= BC_STOP;
          end else if (ph == PH_AW) begin
            ph       <= PH_OFF;
            st       <= SQ_TX;
            bcnt     <= 3'd7;
            sh       <= {nxt_byte[BYTE_W-2:0], 1'b0};
            eng_wbit <= nxt_byte[BYTE_W-1];
            eng_cmd  <= BC_WR;
          end else if (ph == PH_OFF) begin
            st      <= SQ_RSTART;
            eng_cmd <= BC_RSTART;
          end else begin
            st      <= SQ_RX;
            bcnt    <= 3'd7;
            eng_cmd <= BC_RD;
          end
        end
        SQ_RX: if (eng_done) begin
          rx_byte <= {rx_byte[BYTE_W-2:0], eng_rbit};
          eng_go  <= 1'b1;
          if (bcnt == 3'd0) begin
            st       <= SQ_RXACK;
            eng_cmd  <= BC_WR;
            eng_wbit <= 1'b1;              // NACK ends the read
          end else begin
            bcnt    <= bcnt - 3'd1;
            eng_cmd <= BC_RD;
          end
        end
        SQ_RXACK: if (eng_done) begin
          st      <= SQ_STOP;
          eng_go  <= 1'b1;
          eng_cmd <= BC_STOP;
        end
        default: if (eng_done) begin
          st  <= SQ_IDLE;
          fin <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_rd_pkg::*;
#(
  parameter logic [7:0] DIV_RST = 8'd41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              fin,
  input  logic              nack_adr,
  input  logic              nack_off,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] rdata,
  output logic              start,
  output logic              with_off,
  output logic [BYTE_W-1:0] sadr_q,
  output logic [BYTE_W-1:0] off_q,
  output logic [BYTE_W-1:0] div_q,
  output logic              busy_q,
  output logic              done_q
);
  logic              err_q;
  logic [1:0]        aux_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      aux_q    <= 2'b00;
      sadr_q   <= '0;
      off_q    <= '0;
      div_q    <= DIV_RST;
      data_q   <= '0;
      start    <= 1'b0;
      with_off <= 1'b0;
      rdata    <= '0;
    end else begin
      start <= 1'b0;
      if (wen) begin
        case (addr)
          OFS_STAT: begin
            if (wdata[1]) done_q <= 1'b0;
            if (wdata[2]) err_q  <= 1'b0;
          end
          OFS_AUX: aux_q <= aux_q & ~wdata[1:0];
          OFS_CTRL: if (!busy_q && (wdata == CODE_OFS_RD || wdata == CODE_CUR_RD)) begin
            busy_q   <= 1'b1;
            start    <= 1'b1;
            with_off <= (wdata == CODE_OFS_RD);
          end
          OFS_CMD:  if (!busy_q) off_q  <= wdata;
          OFS_SADR: if (!busy_q) sadr_q <= wdata;
          OFS_DIV:  div_q <= wdata;
          default: ;
        endcase
      end
      // completion wins over a same-cycle clear
      if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (nack_adr || nack_off) err_q <= 1'b1;
        if (nack_adr) aux_q[0] <= 1'b1;
        if (nack_off) aux_q[1] <= 1'b1;
        if (!(nack_adr || nack_off)) data_q <= rx_byte;
      end
      case (addr)
        OFS_STAT: rdata <= {5'b0, err_q, done_q, busy_q};
        OFS_AUX:  rdata <= {6'b0, aux_q};
        OFS_CMD:  rdata <= off_q;
        OFS_SADR: rdata <= sadr_q;
        OFS_DATA: rdata <= data_q;
        OFS_DIV:  rdata <= div_q;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/smb_rd_host.sv
module smb_rd_host
  import smb_rd_pkg::*;
#(
  parameter logic [7:0] DIV_RST = 8'd41
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  logic              start, with_off, fin, nack_adr, nack_off;
  logic [BYTE_W-1:0] sadr_q, off_q, div_q, rx_byte;
  logic              busy_q, done_q;
  logic              eng_go, eng_wbit, eng_done, eng_rbit;
  bitcmd_t           eng_cmd;

  smb_regs #(.DIV_RST(DIV_RST)) u_regs (
    .clk(clk), .rst(rst), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .fin(fin), .nack_adr(nack_adr), .nack_off(nack_off), .rx_byte(rx_byte),
    .rdata(reg_rdata), .start(start), .with_off(with_off), .sadr_q(sadr_q),
    .off_q(off_q), .div_q(div_q), .busy_q(busy_q), .done_q(done_q)
  );

  smb_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .with_off(with_off),
    .sadr(sadr_q[BYTE_W-1:1]), .off_byte(off_q),
    .eng_done(eng_done), .eng_rbit(eng_rbit), .eng_go(eng_go),
    .eng_cmd(eng_cmd), .eng_wbit(eng_wbit), .fin(fin),
    .nack_adr(nack_adr), .nack_off(nack_off), .rx_byte(rx_byte)
  );

  smb_bit_eng u_eng (
    .clk(clk), .rst(rst), .go(eng_go), .cmd(eng_cmd), .wbit(eng_wbit),
    .div(div_q), .sda_in(sda_in), .done(eng_done), .rbit(eng_rbit),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low)
  );
endmodule

// File: rtl/smb_rd_host_chk.sv
module smb_rd_host_chk
  import smb_rd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              busy,
  input logic              done,
  input logic [BYTE_W-1:0] sadr_q,
  input logic [BYTE_W-1:0] off_q,
  input logic              scl_low,
  input logic              sda_low,
  input bitcmd_t           eng_cmd
);
  logic good_code;
  assign good_code = (reg_wdata == CODE_OFS_RD) || (reg_wdata == CODE_CUR_RD);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == OFS_CTRL && !busy && good_code) |=> busy);

  p_bad_code_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wen && reg_addr == OFS_CTRL && !busy && !good_code) |=> !busy);

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_sadr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wen && reg_addr == OFS_SADR) |=> $stable(sadr_q));

  p_off_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wen && reg_addr == OFS_CMD) |=> $stable(off_q));

  p_idle_released_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_low && !sda_low));

  p_sda_high_scl_r12: assert property (@(posedge clk) disable iff (rst)
    (!scl_low && !$past(scl_low) && !$stable(sda_low)) |->
      (eng_cmd == BC_START || eng_cmd == BC_RSTART || eng_cmd == BC_STOP));
endmodule

bind smb_rd_host smb_rd_host_chk chk_i (
  .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy_q), .done(done_q), .sadr_q(sadr_q),
  .off_q(off_q), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
  .eng_cmd(u_eng.cmd_q)
);

// File: tb/smb_rd_host_tb_top.sv
module smb_rd_host_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wen = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_drive_low, sda_drive_low;
  logic       s_low;
  logic       scl_bus, sda_bus;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  assign scl_bus = ~scl_drive_low;
  assign sda_bus = ~(sda_drive_low | s_low);

  smb_rd_host dut_i (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_bus),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  // ---------------- slave memory model ----------------
  localparam logic [6:0] SLV = 7'h50;
  function automatic logic [7:0] memv(input logic [7:0] a);
    memv = (a * 8'd13) ^ 8'h3C;
  endfunction

  typedef enum logic [2:0] {SI, SRX, SACK, STX, SMACK} slv_t;
  slv_t       sst;
  logic       ps, pd, kind, rw, nack_off_t;
  logic [3:0] scnt;
  logic [7:0] ssh, ptr, tbyte;

  always @(posedge clk) begin
    if (rst) begin
      sst <= SI; s_low <= 1'b0; ps <= 1'b1; pd <= 1'b1; ptr <= 8'h00;
      kind <= 1'b0; rw <= 1'b0; scnt <= 4'd0; ssh <= 8'h00; tbyte <= 8'h00;
    end else begin
      ps <= scl_bus;
      pd <= sda_bus;
      if (ps && scl_bus && pd && !sda_bus) begin
        sst <= SRX; kind <= 1'b0; scnt <= 4'd0; s_low <= 1'b0;
      end else if (ps && scl_bus && !pd && sda_bus) begin
        sst <= SI; s_low <= 1'b0;
      end else if (!ps && scl_bus) begin
        if (sst == SRX) begin ssh <= {ssh[6:0], sda_bus}; scnt <= scnt + 4'd1; end
      end else if (ps && !scl_bus) begin
        case (sst)
          SRX: if (scnt == 4'd8) begin
            if (!kind) begin
              if (ssh[7:1] == SLV) begin s_low <= 1'b1; sst <= SACK; rw <= ssh[0]; end
              else sst <= SI;
            end else if (!nack_off_t) begin
              ptr <= ssh; s_low <= 1'b1; sst <= SACK;
            end else sst <= SI;
          end
          SACK: begin
            s_low <= 1'b0;
            if (!kind && rw) begin
              sst <= STX; tbyte <= memv(ptr); s_low <= ~memv(ptr)[7]; scnt <= 4'd1;
            end else if (!kind) begin
              sst <= SRX; kind <= 1'b1; scnt <= 4'd0;
            end else sst <= SI;
          end
          STX: if (scnt == 4'd8) begin
            s_low <= 1'b0; sst <= SMACK; ptr <= ptr + 8'd1;
          end else begin
            s_low <= ~tbyte[3'd7 - scnt[2:0]]; scnt <= scnt + 4'd1;
          end
          SMACK: sst <= SI;
          default: ;
        endcase
      end
    end
  end

  // ---------------- SCL high-time monitor ----------------
  logic meas_arm = 1'b0;
  logic meas_got, counting, prev_l;
  int   hcnt, meas;
  always @(posedge clk) begin
    prev_l <= scl_drive_low;
    if (!meas_arm) begin meas_got <= 1'b0; counting <= 1'b0; end
    else if (!meas_got) begin
      if (prev_l && !scl_drive_low) begin counting <= 1'b1; hcnt <= 1; end
      else if (counting && !scl_drive_low) hcnt <= hcnt + 1;
      else if (counting && scl_drive_low) begin meas <= hcnt; meas_got <= 1'b1; end
    end
  end

  // ---------------- scoreboard ----------------
  logic [23:0] exp_q[$];
  logic [23:0] obs_q[$];
  string       tag_q[$];

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [23:0] o, e;
        string t;
        o = obs_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
        check(t, o, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(4'h0, s);
      if (!s[0]) break;
    end
  endtask

  task automatic collect();
    logic [7:0] s, a, d;
    wait_idle();
    rd(4'h0, s); rd(4'h1, a); rd(4'h5, d);
    obs_q.push_back({s, a, d});
  endtask

  // driver: expected item, then the read itself
  task automatic txn(input string t, input logic [7:0] code, input logic [7:0] sa,
                     input logic [7:0] off, input logic [23:0] expv);
    exp_q.push_back(expv); tag_q.push_back(t);
    wr(4'h4, sa); wr(4'h3, off); wr(4'h2, code);
    collect();
  endtask

  task automatic clr();
    wr(4'h0, 8'hFF); wr(4'h1, 8'h1F);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R1..all) actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    nack_off_t = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(4'h0, v); check("R1 status", {16'h0, v}, 24'h0);
    rd(4'h1, v); check("R1 aux", {16'h0, v}, 24'h0);
    rd(4'hE, v); check("R1 divider", {16'h0, v}, 24'd41);
    check("R1 lines released", {22'h0, scl_drive_low, sda_drive_low}, 24'h0);

    wr(4'hE, 8'd3);
    meas_arm = 1'b1;
    // R4 offset read, R5 data, R6 exact success status
    txn("R4 R5 R6 offset read", 8'h48, 8'hA0, 8'h10, {8'h02, 8'h00, memv(8'h10)});
    check("R11 scl high time div=3", meas, 6);
    meas_arm = 1'b0;
    clr();
    // R4 current-pointer read follows slave pointer
    txn("R4 R5 current read 1", 8'h44, 8'hA1, 8'h00, {8'h02, 8'h00, memv(8'h11)});
    clr();
    txn("R4 R5 current read 2", 8'h44, 8'hA1, 8'h00, {8'h02, 8'h00, memv(8'h12)});
    clr();
    // R7 address NACK
    txn("R7 R5 address nack", 8'h48, 8'hA4, 8'h20, {8'h06, 8'h01, memv(8'h12)});
    // R9 clear status only, aux untouched
    wr(4'h0, 8'hFF);
    rd(4'h0, v); check("R9 status cleared", {16'h0, v}, 24'h0);
    rd(4'h1, v); check("R9 aux kept", {16'h0, v}, 24'h01);
    wr(4'h1, 8'h1F);
    rd(4'h1, v); check("R9 aux cleared", {16'h0, v}, 24'h0);
    // R8 offset NACK
    nack_off_t = 1'b1;
    txn("R8 offset nack", 8'h48, 8'hA0, 8'h20, {8'h06, 8'h02, memv(8'h12)});
    nack_off_t = 1'b0;
    clr();
    // R3 unknown start code
    wr(4'h2, 8'h10);
    repeat (20) @(negedge clk);
    rd(4'h0, v); check("R3 bad code no start", {16'h0, v}, 24'h0);
    check("R12 released after bad code", {22'h0, scl_drive_low, sda_drive_low}, 24'h0);
    // R10 writes ignored while busy
    exp_q.push_back({8'h02, 8'h00, memv(8'h05)}); tag_q.push_back("R10 read survives busy writes");
    wr(4'h4, 8'hA0); wr(4'h3, 8'h05); wr(4'h2, 8'h48);
    repeat (20) @(negedge clk);
    wr(4'h3, 8'h77); wr(4'h4, 8'h22); wr(4'h2, 8'h44);
    collect();
    rd(4'h3, v); check("R10 offset held", {16'h0, v}, 24'h05);
    rd(4'h4, v); check("R10 address held", {16'h0, v}, 24'hA0);
    repeat (60) @(negedge clk);
    rd(4'h0, v); check("R10 no second read", {16'h0, v}, 24'h02);
    check("R12 released when idle", {22'h0, scl_drive_low, sda_drive_low}, 24'h0);
    clr();
    // R11 divider 0 acts as 1
    wr(4'hE, 8'd0);
    meas_arm = 1'b1;
    txn("R4 current read div0", 8'h44, 8'hA1, 8'h00, {8'h02, 8'h00, memv(8'h06)});
    check("R11 scl high time div=0", meas, 2);
    meas_arm = 1'b0;
    rd(4'h2, v); check("R2 control reads zero", {16'h0, v}, 24'h0);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule